// File: doc/BRIEF.md
# Dithered Switching-Period Clock Generator

This block produces the switching-period timebase for a synchronous buck converter. A 2-bit frequency code comes from a strap-resistor decoder and picks one of four base switching rates. The block counts system clock cycles to form each switching period. It emits a one-cycle pulse at the start of every period, together with the running position inside the period and the length of the current period. A downstream PWM comparator uses these values to place its gate edges.

To spread conducted and radiated emission energy, the period length follows a triangle profile. Over one half of a 250 µs (4 kHz) sweep, the switching rate rises from the nominal value to 21 % above it. Over the other half it falls back. The rate never goes below nominal. The length is recomputed only at period boundaries, so every period runs whole. The dither can be turned off. A change of code or of the dither enable is applied at the next boundary and restarts the sweep from nominal.

Top module: `pwmclk_gen`

## Requirements
- R1: While reset is held, `period_start` is 1, `period_cnt` is 0 and `period_len` is 800. This is the undithered state of code 00. The first period after reset release is 800 cycles long.
- R2: With the dither off and a 100 MHz clock, the nominal period lengths are 800 cycles for code 00 (125 kHz, also the unset or floating strap), 400 for 01 (250 kHz), 286 for 10 (350 kHz) and 250 for 11 (400 kHz).
- R3: `period_start` is high only in the first cycle of a period, where `period_cnt` is 0. `period_cnt` rises by one each cycle up to `period_len`-1 and then wraps to 0.
- R4: `period_len` stays constant for the whole of a period and changes only in a cycle where `period_start` is high.
- R5: With the dither on, every period length lies between the minimum length and the nominal length of the active code. The minimum lengths are 661, 331, 236 and 207 cycles for codes 00, 01, 10 and 11.
- R6: With the dither on, let t be the number of cycles from the start of the sweep to the start of a period. Let f be t mod 25000, folded so that f stays as it is when f ≤ 12500 and becomes 25000−f otherwise. The period length is then nominal − round((nominal − minimum)·f/12500). The profile repeats every 25000 cycles (4 kHz).
- R7: `freq_sel` and `dith_en` are sampled only in the last cycle of a period. A change in either leaves the running period untouched. The next period is then nominal for the new settings, and the sweep restarts at t = 0.
- R8: While `dith_en` is low, every period has the nominal length of the selected code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (100 MHz by default) |
| rst_n | input | 1 | Active-low synchronous reset |
| freq_sel | input | 2 | Base switching-rate code from the strap decoder |
| dith_en | input | 1 | 1 enables the triangle period dither |
| period_start | output | 1 | High in the first cycle of each switching period |
| period_cnt | output | 16 | Cycle position inside the current period |
| period_len | output | 16 | Length in cycles of the current period |

## Verification
The bench measures every period from pulse to pulse and compares it with a triangle profile that it computes itself in real arithmetic, across a full 25000-cycle sweep for each code. A design that folds the triangle at the wrong point, or that rounds differently, gives periods off by one cycle near the ends of the sweep. A design that lets the sweep dip below nominal breaks the bounds check. Settings are changed in the middle of a period. A design that applies them at once shortens or stretches the running period. A design that forgets to restart the sweep shows a non-nominal first period. Runs that repeat the same code with the dither switched on and off catch a generator that ignores the enable or that leaves the sweep phase running while the dither is off.

// File: rtl/pwmclk_pkg.sv
package pwmclk_pkg;

  // Cycles per switching period for a given rate, rounded to nearest.
  function automatic int unsigned nom_cycles(input int unsigned clk_hz,
                                             input int unsigned f_hz);
    return (clk_hz + f_hz / 2) / f_hz;
  endfunction

  // Shortest period: nominal shrunk by (100+boost)/100, rounded to nearest.
  function automatic int unsigned min_cycles(input int unsigned nom,
                                             input int unsigned boost_pct);
    return (nom * 200 + (100 + boost_pct)) / (2 * (100 + boost_pct));
  endfunction

  // Fold a sweep phase into a rising/falling triangle position.
  function automatic int unsigned tri_fold(input int unsigned phase,
                                           input int unsigned mod_cyc);
    return (phase <= mod_cyc / 2) ? phase : (mod_cyc - phase);
  endfunction

  // Linear interpolation from nominal (pos=0) to minimum (pos=half), rounded.
  function automatic int unsigned dither_len(input int unsigned nom,
                                             input int unsigned mn,
                                             input int unsigned pos,
                                             input int unsigned half);
    return nom - (((nom - mn) * pos + half / 2) / half);
  endfunction

endpackage

// File: rtl/pwmclk_rate_table.sv
module pwmclk_rate_table
  import pwmclk_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned FREQ_HZ [4] = '{125_000, 250_000, 350_000, 400_000},
  parameter int unsigned BOOST_PCT   = 21,
  parameter int unsigned CW          = 16
) (
  input  logic [1:0]    code,
  output logic [CW-1:0] nom_len,
  output logic [CW-1:0] min_len
);

  localparam int unsigned N_RATES = 4;

  logic [CW-1:0] nom_tab [N_RATES];
  logic [CW-1:0] min_tab [N_RATES];

  for (genvar g = 0; g < N_RATES; g++) begin : g_rate
    localparam int unsigned NOM_G = nom_cycles(CLK_HZ, FREQ_HZ[g]);
    localparam int unsigned MIN_G = min_cycles(NOM_G, BOOST_PCT);
    assign nom_tab[g] = CW'(NOM_G);
    assign min_tab[g] = CW'(MIN_G);
  end

  assign nom_len = nom_tab[code];
  assign min_len = min_tab[code];

endmodule

// File: rtl/pwmclk_tri_phase.sv
module pwmclk_tri_phase
  import pwmclk_pkg::*;
#(
  parameter int unsigned MOD_CYC = 25_000,
  parameter int unsigned PW      = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clear,
  output logic [PW-1:0] fold_nxt
);

  logic [PW-1:0] phase;
  logic [PW-1:0] phase_inc;

  assign phase_inc = (phase == PW'(MOD_CYC - 1)) ? '0 : phase + 1'b1;
  assign fold_nxt  = PW'(tri_fold(32'(phase_inc), MOD_CYC));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (clear || !run) begin
      phase <= '0;
    end else begin
      phase <= phase_inc;
    end
  end

endmodule

// File: rtl/pwmclk_period_ctr.sv
module pwmclk_period_ctr #(
  parameter int unsigned CW      = 16,
  parameter int unsigned RST_LEN = 800
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] next_len,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] len,
  output logic          boundary
);

  assign boundary = (cnt == len - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      len <= CW'(RST_LEN);
    end else if (boundary) begin
      cnt <= '0;
      len <= next_len;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pwmclk_gen.sv
module pwmclk_gen
  import pwmclk_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned FREQ_HZ [4] = '{125_000, 250_000, 350_000, 400_000},
  parameter int unsigned BOOST_PCT   = 21,
  parameter int unsigned MOD_HZ      = 4_000,
  parameter int unsigned CW          = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    freq_sel,
  input  logic          dith_en,
  output logic          period_start,
  output logic [CW-1:0] period_cnt,
  output logic [CW-1:0] period_len
);

  localparam int unsigned MOD_CYC = CLK_HZ / MOD_HZ;
  localparam int unsigned HALF    = MOD_CYC / 2;
  localparam int unsigned PW      = $clog2(MOD_CYC + 1);
  localparam int unsigned RST_LEN = nom_cycles(CLK_HZ, FREQ_HZ[0]);

  logic [1:0]    code_q;
  logic          en_q;
  logic          boundary;
  logic          restart_evt;
  logic [1:0]    code_nxt;
  logic          en_nxt;
  logic [CW-1:0] nom_nxt, min_nxt;
  logic [CW-1:0] nom_now, min_now;
  logic [PW-1:0] fold_nxt;
  logic [CW-1:0] next_len;

  // Settings applied at a boundary; any difference restarts the sweep.
  assign restart_evt = boundary && ((freq_sel != code_q) || (dith_en != en_q));
  assign code_nxt    = boundary ? freq_sel : code_q;
  assign en_nxt      = boundary ? dith_en  : en_q;

  pwmclk_rate_table #(
    .CLK_HZ(CLK_HZ), .FREQ_HZ(FREQ_HZ), .BOOST_PCT(BOOST_PCT), .CW(CW)
  ) u_rate_nxt (
    .code(code_nxt), .nom_len(nom_nxt), .min_len(min_nxt)
  );

  pwmclk_rate_table #(
    .CLK_HZ(CLK_HZ), .FREQ_HZ(FREQ_HZ), .BOOST_PCT(BOOST_PCT), .CW(CW)
  ) u_rate_now (
    .code(code_q), .nom_len(nom_now), .min_len(min_now)
  );

  pwmclk_tri_phase #(.MOD_CYC(MOD_CYC), .PW(PW)) u_phase (
    .clk(clk), .rst_n(rst_n), .run(en_q), .clear(restart_evt), .fold_nxt(fold_nxt)
  );

  always_comb begin
    if (!en_nxt || restart_evt) begin
      next_len = nom_nxt;
    end else begin
      next_len = CW'(dither_len(32'(nom_nxt), 32'(min_nxt), 32'(fold_nxt), HALF));
    end
  end

  pwmclk_period_ctr #(.CW(CW), .RST_LEN(RST_LEN)) u_ctr (
    .clk(clk), .rst_n(rst_n), .next_len(next_len),
    .cnt(period_cnt), .len(period_len), .boundary(boundary)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= 2'b00;
      en_q   <= 1'b0;
    end else if (boundary) begin
      code_q <= freq_sel;
      en_q   <= dith_en;
    end
  end

  assign period_start = (period_cnt == '0);

endmodule

// File: rtl/pwmclk_gen_chk.sv
module pwmclk_gen_chk #(
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          period_start,
  input logic [CW-1:0] period_cnt,
  input logic [CW-1:0] period_len,
  input logic          boundary,
  input logic          restart_evt,
  input logic          en_q,
  input logic [CW-1:0] nom_now,
  input logic [CW-1:0] min_now
);

  // R3
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |=> !period_start);

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start |-> period_cnt == $past(period_cnt) + 1'b1);

  // R3
  boundary_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (period_start && period_cnt == '0));

  // R3
  cnt_below_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_cnt < period_len);

  // R4
  len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start |-> $stable(period_len));

  // R5
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period_len <= nom_now) && (period_len >= min_now));

  // R8
  undithered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> period_len == nom_now);

  // R7
  restart_nom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_evt |=> period_len == nom_now);

endmodule

bind pwmclk_gen pwmclk_gen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .period_start(period_start),
  .period_cnt(period_cnt), .period_len(period_len), .boundary(boundary),
  .restart_evt(restart_evt), .en_q(en_q), .nom_now(nom_now), .min_now(min_now)
);

// File: tb/sim_pwmclk_gen.sv
module sim_pwmclk_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  freq_sel = 2'b00;
  logic        dith_en = 1'b0;
  logic        period_start;
  logic [15:0] period_cnt;
  logic [15:0] period_len;

  always #5 clk = ~clk;

  pwmclk_gen u0 (
    .clk(clk), .rst_n(rst_n), .freq_sel(freq_sel), .dith_en(dith_en),
    .period_start(period_start), .period_cnt(period_cnt), .period_len(period_len)
  );

  typedef struct {
    int    len;
    int    nom;
    int    mn;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_run  = 0;
  int n_fail = 0;
  int nom_tab [4] = '{800, 400, 286, 250};
  int min_tab [4] = '{661, 331, 236, 207};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: apply settings mid-period, push the expected period lengths (R6/R7/R8).
  task automatic run(input int code, input bit en, input int n);
    int t;
    t = 0;
    freq_sel = 2'(code);
    dith_en  = en;
    for (int i = 0; i < n; i++) begin
      exp_t e;
      int   f;
      f = t % 25000;
      if (f > 12500) f = 25000 - f;
      e.nom = nom_tab[code];
      e.mn  = min_tab[code];
      if (!en) begin
        e.len = e.nom;
        e.tag = "R8";
      end else begin
        e.len = e.nom - $rtoi(real'(e.nom - e.mn) * real'(f) / 12500.0 + 0.5);
        e.tag = "R6";
      end
      if (i == 0) e.tag = "R7";
      q.push_back(e);
      t += e.len;
    end
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!period_start);
    end
  endtask

  // Monitor: measure periods pulse to pulse and compare against the queue.
  initial begin
    exp_t cur;
    int   cyc;
    int   len0;
    bit   have;
    bit   bad_cnt;
    bit   bad_len;
    have = 0; cyc = 0; len0 = 0; bad_cnt = 0; bad_len = 0;
    wait (rst_n === 1'b1);
    forever begin
      if (period_start) begin
        if (have) begin
          chk(cyc == cur.len, cur.tag, cyc, cur.len);
          chk(cyc <= cur.nom && cyc >= cur.mn, "R5", cyc, cur.nom);
          chk(!bad_cnt, "R3", int'(bad_cnt), 0);
          chk(!bad_len, "R4", int'(bad_len), 0);
        end
        if (q.size() == 0) begin
          chk(1'b0, "R7 unexpected period", 1, 0);
          have = 0;
        end else begin
          cur  = q.pop_front();
          have = 1;
          chk(int'(period_len) == cur.len, (cur.len == cur.nom) ? "R2" : cur.tag,
              int'(period_len), cur.len);
        end
        cyc     = 1;
        bad_cnt = (period_cnt != 16'd0);
        bad_len = 1'b0;
        len0    = int'(period_len);
      end else begin
        cyc++;
        if (int'(period_cnt) != cyc - 1) bad_cnt = 1'b1;
        if (int'(period_len) != len0) bad_len = 1'b1;
      end
      @(negedge clk);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(period_start == 1'b1, "R1", int'(period_start), 1);
    chk(period_cnt == 16'd0, "R1", int'(period_cnt), 0);
    chk(period_len == 16'd800, "R1", int'(period_len), 800);
    begin
      exp_t e0;
      e0.len = 800; e0.nom = 800; e0.mn = 661; e0.tag = "R1";
      q.push_back(e0);
    end
    rst_n = 1'b1;
    run(0, 1'b1, 40);
    run(1, 1'b1, 80);
    run(2, 1'b0, 10);
    run(2, 1'b1, 100);
    run(3, 1'b1, 110);
    run(3, 1'b0, 5);
    run(1, 1'b0, 5);
    run(0, 1'b0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 190000, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule